// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small multi-cycle processor. It holds a 6-bit microstate and reads three lookup tables. The main table turns the current microstate into a 26-bit control word. That word carries the datapath strobes and a 6-bit field that names the following microstate. The dispatch table turns a 4-bit instruction opcode into a microstate. The branch table picks one of two microstates from the comparison flag that the datapath has registered.

Two flags in the control word decide which table supplies the next microstate. When neither flag is set, the control word's own successor field wins. The dispatch flag hands control to the opcode, which is how fetch ends. The branch flag hands control to the comparison result. All three tables are parameters, so one netlist can carry any microprogram.

A stepping mode lets a debugger move the machine forward one microstate at a time. Setting both selection flags in one word is illegal. When that happens the block keeps its current microstate and raises an error output.

Top module: `ucode_sequencer`

## Requirements
- R1: While rst_ni is low the microstate is 0, asynchronously, and ctrl_o equals main-table entry 0.
- R2: ctrl_o is the main-table entry at the current microstate, valid in the same cycle. Its bits 5:0 are the successor field, bit 24 is the dispatch flag and bit 25 is the branch flag. Bits 23:6 are strobes passed through unchanged.
- R3: On an advancing edge, if neither flag is set, the microstate becomes ctrl_o bits 5:0.
- R4: On an advancing edge, if only the dispatch flag (bit 24) is set, the microstate becomes the dispatch-table entry at index opcode_i.
- R5: On an advancing edge, if only the branch flag (bit 25) is set, the microstate becomes branch-table entry 0 when cmp_i is 0 and entry 1 when cmp_i is 1.
- R6: sel_err_o is 1 exactly when bits 24 and 25 are both set. In that case the microstate does not change, even on an advancing edge.
- R7: With step_mode_i low, every rising edge is an advancing edge. With step_mode_i high, only edges where step_i is 1 advance; on any other edge the microstate is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_mode_i | input | 1 | Selects single-step operation |
| step_i | input | 1 | Advance enable while stepping |
| opcode_i | input | 4 | Instruction opcode, indexes the dispatch table |
| cmp_i | input | 1 | Registered comparison flag, indexes the branch table |
| state_o | output | 6 | Current microstate |
| ctrl_o | output | 26 | Control word for the current microstate |
| sel_err_o | output | 1 | Both selection flags set in the current word |

## Verification
ctrl_o and sel_err_o follow the microstate in the same cycle, because they are combinational. A new microstate appears one rising edge after the inputs that selected it. A reset takes effect at once. The bench changes its inputs only at falling edges and compares state_o, ctrl_o and sel_err_o with a behavioural model at every falling edge. The model updates on the same rising edges as the design, so each comparison falls half a cycle after the result becomes due.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

  localparam int STATE_W_D = 6;
  localparam int OP_W_D    = 4;
  localparam int CW_W_D    = 26;

  typedef enum logic [1:0] {
    SEL_MAIN = 2'b00,
    SEL_SEQ  = 2'b01,
    SEL_COND = 2'b10,
    SEL_BAD  = 2'b11
  } next_sel_e;

  // Demo microprogram: a linear walk with fetch dispatch at state 2.
  function automatic logic [(2**STATE_W_D)*CW_W_D-1:0] default_main_table();
    logic [(2**STATE_W_D)*CW_W_D-1:0] t;
    logic [CW_W_D-1:0] w;
    t = '0;
    for (int s = 0; s < 2**STATE_W_D; s++) begin
      w = '0;
      w[STATE_W_D-1:0] = STATE_W_D'((s + 1) % (2**STATE_W_D));
      if (s == 2) w[CW_W_D-2] = 1'b1;
      if (s == 40) w[CW_W_D-1] = 1'b1;
      t[s*CW_W_D +: CW_W_D] = w;
    end
    return t;
  endfunction

  function automatic logic [(2**OP_W_D)*STATE_W_D-1:0] default_seq_table();
    logic [(2**OP_W_D)*STATE_W_D-1:0] t;
    for (int k = 0; k < 2**OP_W_D; k++)
      t[k*STATE_W_D +: STATE_W_D] = STATE_W_D'(8 + 2*k);
    return t;
  endfunction

  function automatic logic [2*STATE_W_D-1:0] default_cond_table();
    return {STATE_W_D'(48), STATE_W_D'(0)};
  endfunction

endpackage

// File: rtl/ucode_lut.sv
module ucode_lut #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 26,
  parameter logic [DEPTH*WIDTH-1:0] TABLE = '0,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [WIDTH-1:0] data_o
);

  logic [WIDTH-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign rom[i] = TABLE[i*WIDTH +: WIDTH];
  end

  assign data_o = rom[idx_i];

endmodule

// File: rtl/ucode_next_sel.sv
module ucode_next_sel
  import ucode_pkg::*;
#(
  parameter int STATE_W = 6
) (
  input  logic [STATE_W-1:0] cur_state_i,
  input  logic [STATE_W-1:0] main_next_i,
  input  logic [STATE_W-1:0] seq_next_i,
  input  logic [STATE_W-1:0] cond_next_i,
  input  logic               op_test_i,
  input  logic               chk_cmp_i,
  input  logic               step_mode_i,
  input  logic               step_i,
  output logic [STATE_W-1:0] next_state_o,
  output logic               advance_o,
  output logic               sel_err_o
);

  next_sel_e sel;

  assign sel       = next_sel_e'({chk_cmp_i, op_test_i});
  assign advance_o = !step_mode_i || step_i;
  assign sel_err_o = (sel == SEL_BAD);

  always_comb begin
    unique case (sel)
      SEL_MAIN: next_state_o = main_next_i;
      SEL_SEQ:  next_state_o = seq_next_i;
      SEL_COND: next_state_o = cond_next_i;
      default:  next_state_o = cur_state_i;  // illegal select: hold
    endcase
  end

endmodule

// File: rtl/ucode_state_reg.sv
module ucode_state_reg #(
  parameter int STATE_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [STATE_W-1:0] d_i,
  output logic [STATE_W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end

  // R1: reset forces the first fetch microstate
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_zero_r1: assert (q_o == '0)
        else $error("state not zero under reset");
    end
  end

endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import ucode_pkg::*;
#(
  parameter int STATE_W = STATE_W_D,
  parameter int OP_W    = OP_W_D,
  parameter int CW_W    = CW_W_D,
  parameter logic [(2**STATE_W)*CW_W-1:0]   MAIN_TABLE = default_main_table(),
  parameter logic [(2**OP_W)*STATE_W-1:0]   SEQ_TABLE  = default_seq_table(),
  parameter logic [2*STATE_W-1:0]           COND_TABLE = default_cond_table()
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_mode_i,
  input  logic               step_i,
  input  logic [OP_W-1:0]    opcode_i,
  input  logic               cmp_i,
  output logic [STATE_W-1:0] state_o,
  output logic [CW_W-1:0]    ctrl_o,
  output logic               sel_err_o
);

  localparam int N_STATES   = 2**STATE_W;
  localparam int N_OPS      = 2**OP_W;
  localparam int BIT_OPTEST = CW_W - 2;
  localparam int BIT_CHKCMP = CW_W - 1;

  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] seq_next;
  logic [STATE_W-1:0] cond_next;
  logic [STATE_W-1:0] next_state;
  logic               advance;

  ucode_lut #(.DEPTH(N_STATES), .WIDTH(CW_W), .TABLE(MAIN_TABLE)) u_main (
    .idx_i (state_q),
    .data_o(ctrl_o)
  );

  ucode_lut #(.DEPTH(N_OPS), .WIDTH(STATE_W), .TABLE(SEQ_TABLE)) u_seq (
    .idx_i (opcode_i),
    .data_o(seq_next)
  );

  ucode_lut #(.DEPTH(2), .WIDTH(STATE_W), .TABLE(COND_TABLE)) u_cond (
    .idx_i (cmp_i),
    .data_o(cond_next)
  );

  ucode_next_sel #(.STATE_W(STATE_W)) u_sel (
    .cur_state_i (state_q),
    .main_next_i (ctrl_o[STATE_W-1:0]),
    .seq_next_i  (seq_next),
    .cond_next_i (cond_next),
    .op_test_i   (ctrl_o[BIT_OPTEST]),
    .chk_cmp_i   (ctrl_o[BIT_CHKCMP]),
    .step_mode_i (step_mode_i),
    .step_i      (step_i),
    .next_state_o(next_state),
    .advance_o   (advance),
    .sel_err_o   (sel_err_o)
  );

  ucode_state_reg #(.STATE_W(STATE_W)) u_state (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (advance),
    .d_i   (next_state),
    .q_o   (state_q)
  );

  assign state_o = state_q;

  // R3: successor field path
  p_main_path_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance && !ctrl_o[BIT_OPTEST] && !ctrl_o[BIT_CHKCMP])
      |=> state_q == $past(ctrl_o[STATE_W-1:0]));

  // R4: opcode dispatch path
  p_dispatch_path_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance && ctrl_o[BIT_OPTEST] && !ctrl_o[BIT_CHKCMP])
      |=> state_q == $past(seq_next));

  // R5: branch path
  p_branch_path_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance && !ctrl_o[BIT_OPTEST] && ctrl_o[BIT_CHKCMP])
      |=> state_q == $past(cond_next));

  // R6: illegal select holds the microstate
  p_bad_sel_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_err_o |=> $stable(state_q));

  // R7: no step pulse, no movement
  p_step_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_mode_i && !step_i) |=> $stable(state_q));

endmodule

// File: tb/ucode_sequencer_tb.sv
module ucode_sequencer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SW = 6;
  localparam int OW = 4;
  localparam int CW = 26;

  function automatic logic [64*CW-1:0] tb_main();
    logic [64*CW-1:0] t;
    logic [CW-1:0] w;
    for (int s = 0; s < 64; s++) begin
      w = '0;
      w[5:0]  = 6'((s*5 + 3) % 64);
      w[23:6] = 18'((s*37 + 11) * 613);
      w[24]   = (s % 7 == 1);
      w[25]   = (s % 11 == 4);
      t[s*CW +: CW] = w;
    end
    return t;
  endfunction

  function automatic logic [16*SW-1:0] tb_seq();
    logic [16*SW-1:0] t;
    for (int k = 0; k < 16; k++)
      t[k*SW +: SW] = (k == 9) ? 6'd15 : 6'((k*9 + 2) % 64);
    return t;
  endfunction

  localparam logic [64*CW-1:0] T_MAIN = tb_main();
  localparam logic [16*SW-1:0] T_SEQ  = tb_seq();
  localparam logic [2*SW-1:0]  T_COND = {6'd20, 6'd33};  // true -> 20, false -> 33

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          step_mode = 1'b0;
  logic          step = 1'b0;
  logic [OW-1:0] opcode = '0;
  logic          cmp = 1'b0;
  logic [SW-1:0] state;
  logic [CW-1:0] ctrl;
  logic          sel_err;

  int checks = 0;
  int failures = 0;
  int n_r3 = 0, n_r4 = 0, n_r5 = 0, n_r6 = 0, n_r7 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ucode_sequencer #(
    .MAIN_TABLE(T_MAIN), .SEQ_TABLE(T_SEQ), .COND_TABLE(T_COND)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .step_mode_i(step_mode), .step_i(step),
    .opcode_i(opcode), .cmp_i(cmp), .state_o(state), .ctrl_o(ctrl),
    .sel_err_o(sel_err)
  );

  function automatic logic [CW-1:0] m_word(int s);
    return T_MAIN[s*CW +: CW];
  endfunction

  // reference model
  int    m_state = 0;
  string m_tag = "R1";

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_state <= 0;
      m_tag   <= "R1";
    end else if (step_mode && !step) begin
      m_tag <= "R7";
      n_r7++;
    end else if (m_word(m_state)[24] && m_word(m_state)[25]) begin
      m_tag <= "R6";
      n_r6++;
    end else if (m_word(m_state)[24]) begin
      m_state <= int'(T_SEQ[int'(opcode)*SW +: SW]);
      m_tag   <= "R4";
      n_r4++;
    end else if (m_word(m_state)[25]) begin
      m_state <= int'(T_COND[int'(cmp)*SW +: SW]);
      m_tag   <= "R5";
      n_r5++;
    end else begin
      m_state <= int'(m_word(m_state)[5:0]);
      m_tag   <= "R3";
      n_r3++;
    end
  end

  task automatic check_val(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [CW-1:0] w;
    w = m_word(m_state);
    check_val(m_tag, "state", longint'(state), longint'(m_state));
    check_val("R2", "ctrl", longint'(ctrl), longint'(w));
    check_val("R6", "sel_err", longint'(sel_err), longint'(w[24] & w[25]));
  endtask

  task automatic cycle();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) cycle();
    check_val("R1", "reset state", longint'(state), 0);
    check_val("R1", "reset ctrl", longint'(ctrl), longint'(m_word(0)));
    rst_ni = 1'b1;

    // R3 R4 R5: free running with random opcode/compare
    for (int i = 0; i < 1500; i++) begin
      cycle();
      opcode = OW'($urandom);
      cmp    = 1'($urandom);
      if (i % 150 == 149) rst_ni = 1'b0;   // R1: async reset mid-run
      else rst_ni = 1'b1;
    end

    // R7: single-step mode
    step_mode = 1'b1;
    for (int i = 0; i < 1500; i++) begin
      cycle();
      step   = ($urandom % 3 == 0);
      opcode = OW'($urandom);
      cmp    = 1'($urandom);
      if (i % 200 == 199) rst_ni = 1'b0;
      else rst_ni = 1'b1;
    end

    // R6: steer into the illegal-select microstate and stay there
    step_mode = 1'b0;
    step = 1'b0;
    rst_ni = 1'b0;
    cycle();
    rst_ni = 1'b1;
    opcode = 4'd9;
    for (int i = 0; i < 200; i++) cycle();
    check_val("R6", "stuck state", longint'(state), 15);
    check_val("R6", "stuck flag", longint'(sel_err), 1);

    // R7: step pulse alone does not leave a held bad state
    step_mode = 1'b1;
    step = 1'b1;
    repeat (4) cycle();
    check_val("R7", "step on bad sel", longint'(state), 15);

    check_val("R3", "main path taken", longint'(n_r3 > 0), 1);
    check_val("R4", "dispatch path taken", longint'(n_r4 > 0), 1);
    check_val("R5", "branch path taken", longint'(n_r5 > 0), 1);
    check_val("R6", "bad select seen", longint'(n_r6 > 0), 1);
    check_val("R7", "step hold seen", longint'(n_r7 > 0), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule